// File: doc/BRIEF.md
# Paged Word-Address Counter

This block holds the current word address of a byte-wide nonvolatile memory of 131,072 bytes, arranged as 512 pages of 256 bytes. A bus front end loads the address in three parts as they arrive: a single extension bit taken from the device-select byte, then a high address byte, then a low address byte. After that, it pulses an increment strobe after each data byte moves.

The step rule depends on the traffic direction. During writes only the in-page offset advances, and it wraps inside the same page. During reads the whole address advances, and it wraps from the final byte of the memory back to zero. Between transactions the register keeps its value. A current-address read therefore starts at one past the last byte accessed.

The address is registered. Every strobe sampled on a rising clock edge shows on the output after that edge.

Top module: `eac_addr_counter`

## Requirements
- R1: While `rst_n` is low the address is zero, and it stays zero after reset until a strobe arrives.
- R2: A cycle with `ld_top_i` high loads `top_bit_i` into address bit 16. Bits 15..0 are unchanged.
- R3: A cycle with `ld_hi_i` high loads `hi_byte_i` into address bits 15..8. The other bits are unchanged.
- R4: A cycle with `ld_lo_i` high loads `lo_byte_i` into address bits 7..0. The other bits are unchanged.
- R5: An increment with `rd_mode_i` low (write) adds one to bits 7..0 only. Bits 16..8, the page number, are unchanged.
- R6: A write increment from offset 0xFF gives offset 0x00 in the same page. For example, 0x123FF goes to 0x12300.
- R7: An increment with `rd_mode_i` high (read) adds one to the full 17-bit address, so carries cross page boundaries. For example, 0x0FFFF goes to 0x10000.
- R8: A read increment from 0x1FFFF gives 0x00000.
- R9: With no load or increment strobe, the address keeps its value for any number of cycles.
- R10: When any load strobe and `inc_i` are high in the same cycle, only the loads take effect. Fields that are not loaded keep their value.
- R11: The wrap rule is chosen separately for each increment from that cycle's `rd_mode_i`, so mixed read and write traffic follows R5 to R8 step by step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_mode_i | input | 1 | 1 selects the read wrap rule, 0 selects the write wrap rule |
| inc_i | input | 1 | Advance the address by one byte |
| ld_top_i | input | 1 | Load the extension bit |
| top_bit_i | input | 1 | Extension bit value (address MSB) |
| ld_hi_i | input | 1 | Load the high address byte |
| hi_byte_i | input | 8 | High address byte value |
| ld_lo_i | input | 1 | Load the low address byte |
| lo_byte_i | input | 8 | Low address byte value |
| addr_o | output | 17 | Current word address |

## Verification
Every result is due exactly one rising edge after the strobe that causes it, because the output is the only register between input and output. The bench changes inputs on the falling edge and reads `addr_o` on the next falling edge, half a period after the capturing edge. The behavioural model updates on that same rising edge and is compared at every falling edge. The directed cases are the in-page wrap, the page-crossing carry, the end-of-memory wrap, load-over-increment, and idle hold. Each is checked against literal expected addresses.

// File: rtl/eac_pkg.sv
package eac_pkg;
   typedef enum logic {
      EAC_WRITE = 1'b0,
      EAC_READ  = 1'b1
   } eac_mode_e;

   function automatic int unsigned eac_addr_width(input int unsigned xbits,
                                                  input int unsigned byte_w);
      return xbits + 2 * byte_w;
   endfunction
endpackage

// File: rtl/eac_ofs_step.sv
module eac_ofs_step #(
   parameter int unsigned OFS_W = 8
) (
   input  logic [OFS_W-1:0] ofs_i,
   output logic [OFS_W-1:0] ofs_o,
   output logic             carry_o
);
   localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

   always_comb begin
      ofs_o   = ofs_i + ONE;
      carry_o = &ofs_i;
   end
endmodule

// File: rtl/eac_page_step.sv
module eac_page_step #(
   parameter int unsigned PAGE_W      = 9,
   parameter int unsigned OFS_W       = 8,
   parameter bit          SPLIT_CARRY = 1'b1
) (
   input  logic [PAGE_W-1:0] page_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic              carry_i,
   output logic [PAGE_W-1:0] page_o
);
   localparam int unsigned FULL_W = PAGE_W + OFS_W;

   generate
      if (SPLIT_CARRY) begin : g_split
         logic [PAGE_W-1:0] cin;
         always_comb begin
            cin    = '0;
            cin[0] = carry_i;
            page_o = page_i + cin;
         end
      end else begin : g_flat
         logic [FULL_W-1:0] sum;
         logic [FULL_W-1:0] one;
         logic              unused_carry;
         always_comb begin
            one          = '0;
            one[0]       = 1'b1;
            sum          = {page_i, ofs_i} + one;
            page_o       = sum[FULL_W-1:OFS_W];
            unused_carry = carry_i;
         end
      end
   endgenerate
endmodule

// File: rtl/eac_next_sel.sv
module eac_next_sel #(
   parameter int unsigned XBITS  = 1,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned ADDR_W = XBITS + 2 * BYTE_W
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] step_i,
   input  logic              inc_i,
   input  logic              ld_top_i,
   input  logic [XBITS-1:0]  top_bit_i,
   input  logic              ld_hi_i,
   input  logic [BYTE_W-1:0] hi_byte_i,
   input  logic              ld_lo_i,
   input  logic [BYTE_W-1:0] lo_byte_i,
   output logic [ADDR_W-1:0] nxt_o
);
   localparam int unsigned LO_LSB  = 0;
   localparam int unsigned HI_LSB  = BYTE_W;
   localparam int unsigned TOP_LSB = 2 * BYTE_W;

   logic any_ld;

   always_comb begin
      any_ld = ld_top_i | ld_hi_i | ld_lo_i;
      nxt_o  = cur_i;
      if (any_ld) begin
         if (ld_top_i) nxt_o[TOP_LSB +: XBITS] = top_bit_i;
         if (ld_hi_i)  nxt_o[HI_LSB  +: BYTE_W] = hi_byte_i;
         if (ld_lo_i)  nxt_o[LO_LSB  +: BYTE_W] = lo_byte_i;
      end else if (inc_i) begin
         nxt_o = step_i;
      end
   end
endmodule

// File: rtl/eac_addr_counter.sv
module eac_addr_counter #(
   parameter int unsigned XBITS       = 1,
   parameter int unsigned BYTE_W      = 8,
   parameter bit          SPLIT_CARRY = 1'b1,
   localparam int unsigned ADDR_W = XBITS + 2 * BYTE_W,
   localparam int unsigned OFS_W  = BYTE_W,
   localparam int unsigned PAGE_W = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_mode_i,
   input  logic              inc_i,
   input  logic              ld_top_i,
   input  logic [XBITS-1:0]  top_bit_i,
   input  logic              ld_hi_i,
   input  logic [BYTE_W-1:0] hi_byte_i,
   input  logic              ld_lo_i,
   input  logic [BYTE_W-1:0] lo_byte_i,
   output logic [ADDR_W-1:0] addr_o
);
   import eac_pkg::*;

   generate
      if (XBITS < 1)  begin : g_bad_x $error("XBITS must be at least 1"); end
      if (BYTE_W < 2) begin : g_bad_b $error("BYTE_W must be at least 2"); end
      if (ADDR_W != eac_addr_width(XBITS, BYTE_W)) begin : g_bad_w
         $error("address width mismatch");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_d;
   logic [ADDR_W-1:0] step;
   logic [OFS_W-1:0]  ofs_nxt;
   logic              ofs_carry;
   logic [PAGE_W-1:0] page_rd;
   eac_mode_e         mode;

   eac_ofs_step #(.OFS_W(OFS_W)) i_ofs (
      .ofs_i  (addr_q[OFS_W-1:0]),
      .ofs_o  (ofs_nxt),
      .carry_o(ofs_carry)
   );

   eac_page_step #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .SPLIT_CARRY(SPLIT_CARRY)) i_page (
      .page_i (addr_q[ADDR_W-1:OFS_W]),
      .ofs_i  (addr_q[OFS_W-1:0]),
      .carry_i(ofs_carry),
      .page_o (page_rd)
   );

   always_comb begin
      mode = eac_mode_e'(rd_mode_i);
      if (mode == EAC_READ) step = {page_rd, ofs_nxt};
      else                  step = {addr_q[ADDR_W-1:OFS_W], ofs_nxt};
   end

   eac_next_sel #(.XBITS(XBITS), .BYTE_W(BYTE_W)) i_sel (
      .cur_i    (addr_q),
      .step_i   (step),
      .inc_i    (inc_i),
      .ld_top_i (ld_top_i),
      .top_bit_i(top_bit_i),
      .ld_hi_i  (ld_hi_i),
      .hi_byte_i(hi_byte_i),
      .ld_lo_i  (ld_lo_i),
      .lo_byte_i(lo_byte_i),
      .nxt_o    (addr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_d;
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/eac_addr_counter_chk.sv
module eac_addr_counter_chk #(
   parameter int unsigned XBITS  = 1,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned ADDR_W = XBITS + 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_mode_i,
   input logic              inc_i,
   input logic              ld_top_i,
   input logic [XBITS-1:0]  top_bit_i,
   input logic              ld_hi_i,
   input logic [BYTE_W-1:0] hi_byte_i,
   input logic              ld_lo_i,
   input logic [BYTE_W-1:0] lo_byte_i,
   input logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
   localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);

   logic any_ld;
   assign any_ld = ld_top_i | ld_hi_i | ld_lo_i;

   always_comb if (!rst_n) AST_RESET_ZERO: assert (addr_o == '0); // R1

   AST_LOAD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      ld_top_i |=> addr_o[ADDR_W-1 -: XBITS] == $past(top_bit_i)); // R2
   AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hi_i |=> addr_o[2*BYTE_W-1 -: BYTE_W] == $past(hi_byte_i)); // R3
   AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo_i |=> addr_o[BYTE_W-1:0] == $past(lo_byte_i)); // R4
   AST_WR_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !any_ld && !rd_mode_i) |=>
         addr_o[ADDR_W-1:BYTE_W] == $past(addr_o[ADDR_W-1:BYTE_W])); // R5
   AST_WR_OFS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !any_ld && !rd_mode_i) |=>
         addr_o[BYTE_W-1:0] == ($past(addr_o[BYTE_W-1:0]) + ONE_B)); // R6
   AST_RD_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !any_ld && rd_mode_i) |=> addr_o == ($past(addr_o) + ONE_A)); // R7
   AST_RD_END_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !any_ld && rd_mode_i && (&addr_o)) |=> addr_o == '0); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !any_ld) |=> $stable(addr_o)); // R9
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && ld_lo_i && !ld_hi_i && !ld_top_i) |=>
         addr_o[ADDR_W-1:BYTE_W] == $past(addr_o[ADDR_W-1:BYTE_W])); // R10
endmodule

bind eac_addr_counter eac_addr_counter_chk #(.XBITS(XBITS), .BYTE_W(BYTE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .rd_mode_i(rd_mode_i), .inc_i(inc_i),
   .ld_top_i(ld_top_i), .top_bit_i(top_bit_i), .ld_hi_i(ld_hi_i),
   .hi_byte_i(hi_byte_i), .ld_lo_i(ld_lo_i), .lo_byte_i(lo_byte_i),
   .addr_o(addr_o)
);

// File: tb/test_eac_addr_counter.sv
`timescale 1ns/1ps
module test_eac_addr_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_mode_i = 1'b0, inc_i = 1'b0;
   logic        ld_top_i = 1'b0, ld_hi_i = 1'b0, ld_lo_i = 1'b0;
   logic [0:0]  top_bit_i = '0;
   logic [7:0]  hi_byte_i = '0, lo_byte_i = '0;
   logic [16:0] addr_o;

   int   n_run = 0, n_fail = 0;
   bit   done = 0;
   int   mdl;

   always #5 clk = ~clk;

   eac_addr_counter i_eac_addr_counter (
      .clk(clk), .rst_n(rst_n), .rd_mode_i(rd_mode_i), .inc_i(inc_i),
      .ld_top_i(ld_top_i), .top_bit_i(top_bit_i), .ld_hi_i(ld_hi_i),
      .hi_byte_i(hi_byte_i), .ld_lo_i(ld_lo_i), .lo_byte_i(lo_byte_i),
      .addr_o(addr_o)
   );

   // behavioural reference: integer address, page = addr / 256
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdl = 0;
      else if (ld_top_i || ld_hi_i || ld_lo_i) begin
         if (ld_top_i) mdl = (mdl % 65536) + 65536 * int'(top_bit_i);
         if (ld_hi_i)  mdl = (mdl / 65536) * 65536 + 256 * int'(hi_byte_i) + (mdl % 256);
         if (ld_lo_i)  mdl = (mdl / 256) * 256 + int'(lo_byte_i);
      end else if (inc_i) begin
         if (rd_mode_i) mdl = (mdl + 1) % 131072;
         else           mdl = (mdl / 256) * 256 + ((mdl % 256) + 1) % 256;
      end
   end

   task automatic chk(input string req, input int exp);
      n_run++;
      if (int'(addr_o) !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%05h expected=%05h", req, addr_o, exp);
      end
   endtask

   // R11: model compared on every falling edge
   always @(negedge clk) if (rst_n && !done) chk("R11", mdl);

   task automatic tick; @(negedge clk); endtask
   task automatic clr;
      inc_i = 0; ld_top_i = 0; ld_hi_i = 0; ld_lo_i = 0;
   endtask
   task automatic load(input int a);
      top_bit_i = 1'(a >> 16); hi_byte_i = 8'(a >> 8); lo_byte_i = 8'(a);
      ld_top_i = 1; tick; clr;
      ld_hi_i = 1;  tick; clr;
      ld_lo_i = 1;  tick; clr;
   endtask
   task automatic step(input bit rd);
      rd_mode_i = rd; inc_i = 1; tick; clr;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      tick; tick;
      chk("R1", 0);
      rst_n = 1; tick; tick;
      chk("R1", 0);
      top_bit_i = 1; ld_top_i = 1; tick; clr; chk("R2", 'h10000);
      hi_byte_i = 8'h23; ld_hi_i = 1; tick; clr; chk("R3", 'h12300);
      lo_byte_i = 8'h45; ld_lo_i = 1; tick; clr; chk("R4", 'h12345);
      step(0); chk("R5", 'h12346);
      load('h123FE);
      step(0); chk("R5", 'h123FF);
      step(0); chk("R6", 'h12300);
      step(0); chk("R6", 'h12301);
      load('h0FFFE);
      step(1); chk("R7", 'h0FFFF);
      step(1); chk("R7", 'h10000);
      load('h004FF);
      step(1); chk("R7", 'h00500);
      load('h1FFFF);
      step(1); chk("R8", 'h00000);
      load('h1FFFF);
      step(0); chk("R6", 'h1FF00);
      for (int i = 0; i < 5; i++) begin
         rd_mode_i = i[0]; hi_byte_i = 8'(i); lo_byte_i = 8'(3 * i); tick;
      end
      chk("R9", 'h1FF00);
      lo_byte_i = 8'h10; ld_lo_i = 1; inc_i = 1; rd_mode_i = 1; tick; clr;
      chk("R10", 'h1FF10);
      hi_byte_i = 8'hAA; ld_hi_i = 1; inc_i = 1; rd_mode_i = 0; tick; clr;
      chk("R10", 'h1AA10);
      for (int i = 0; i < 2000; i++) begin
         int r = $urandom_range(0, 99);
         rd_mode_i = 1'($urandom_range(0, 1));
         top_bit_i = 1'($urandom_range(0, 1));
         hi_byte_i = 8'($urandom_range(0, 255));
         lo_byte_i = 8'($urandom_range(250, 255));
         inc_i    = (r < 70);
         ld_top_i = (r >= 90 && r < 93);
         ld_hi_i  = (r >= 88 && r < 95);
         ld_lo_i  = (r >= 85 && r < 97);
         tick;
      end
      clr; tick;
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule